// File: doc/BRIEF.md
# Multi-Grant Round-Robin Arbiter

This block shares a resource among `N` requesters and can hand out up to `M` grants in the same clock cycle. A pointer register names the requester that currently has top priority. Each cycle the requesters are scanned in circular order, starting at the pointer and wrapping from the top port back to port 0. The first `M` asserted requests met on that scan are granted in that same cycle. The pointer then moves one position past the last port granted, so the ports that were just served fall to the back of the queue.

The search is built from a multi-select priority encoder: a chain of saturating counters that passes on the first `limit` ones of a vector. One encoder runs over the requests at or above the pointer, selected by a thermometer mask. A second encoder runs over the requests below the pointer and fills only the grant slots the first one left unused. An accept input gates the whole decision. While accept is low, no grants are issued and the pointer holds.

Top module: `rrm_arbiter`

## Requirements
- R1: Every asserted bit of `grantVec` corresponds to an asserted bit of `reqVec` in the same cycle.
- R2: While `acceptIn` is 1, the number of set bits in `grantVec` equals the smaller of `M` and the number of set bits in `reqVec`.
- R3: While `acceptIn` is 0, `grantVec` is all zeros and the priority pointer keeps its value.
- R4: The ports granted are the first `M` requesting ports met when scanning port indices upward from the pointer, wrapping from port `N-1` to port 0.
- R5: After a clock edge at which at least one grant was issued, the pointer holds the index one past the last port granted in scan order, wrapping from `N-1` to 0.
- R6: After a clock edge at which no grant was issued, the pointer is unchanged.
- R7: A synchronous active-high reset sets the pointer to port 0. With all requests asserted right after reset, ports 0 to `M-1` are granted.
- R8: Under continuous full load with `acceptIn` held at 1, every port is granted at least once in every window of ceil(`N`/`M`) consecutive cycles.
- R9: Grants depend combinationally on the current `reqVec`, `acceptIn` and pointer, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| reqVec | input | N | One request bit per port; bit i is port i |
| acceptIn | input | 1 | When 1, grants are issued and the pointer may advance |
| grantVec | output | N | One grant bit per port, valid in the cycle of the request |

## Verification
The bound checker checks the following on every cycle: grants form a subset of the requests, the grant count matches min(M, requests) while accepted, outputs are silent while accept is low, the pointer holds after an idle cycle, and the pointer is at zero after reset. Only the bench's scenarios can show the exact choice of ports and the pointer's motion past a wrap, because they need a circular reference model. The same holds for the absence of starvation, which needs a window of several cycles under full load.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic grantEn;   // pass the computed grants to the port
  } rrm_strobe_t;
endpackage

// File: rtl/rrm_mpe.sv
// Multi-select priority encoder: passes the first `limit` ones of vec,
// scanning from bit 0 upward, using a chain of saturating counters.
module rrm_mpe #(
  parameter int N     = 8,
  parameter int CNT_W = 2
) (
  input  logic [N-1:0]     vec,
  input  logic [CNT_W-1:0] limit,
  output logic [N-1:0]     sel,
  output logic [CNT_W-1:0] selCount
);
  logic [CNT_W-1:0] run [N+1];

  assign run[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign sel[i]   = vec[i] && (run[i] < limit);
    assign run[i+1] = sel[i] ? run[i] + CNT_W'(1) : run[i];
  end

  assign selCount = run[N];
endmodule

// File: rtl/rrm_datapath.sv
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int N     = 8,
  parameter int M     = 3,
  parameter int PTR_W = 3,
  parameter int CNT_W = 2
) (
  input  logic [N-1:0]     reqVec,
  input  logic [PTR_W-1:0] curPtr,
  input  rrm_strobe_t      strobe,
  output logic [N-1:0]     grantVec,
  output logic             anyGrant,
  output logic [PTR_W-1:0] nextPtr
);
  logic [N-1:0]     hiMask;
  logic [N-1:0]     hiReq, loReq;
  logic [N-1:0]     hiSel, loSel, rawGrant;
  logic [CNT_W-1:0] hiCount, loCount, loLimit;
  logic [PTR_W-1:0] hiTop, loTop, lastIdx;

  // Thermometer mask: ports at or above the pointer.
  always_comb begin
    for (int i = 0; i < N; i++) hiMask[i] = (PTR_W'(i) >= curPtr);
  end

  assign hiReq = reqVec & hiMask;
  assign loReq = reqVec & ~hiMask;

  rrm_mpe #(.N(N), .CNT_W(CNT_W)) hiPass_i (
    .vec(hiReq), .limit(CNT_W'(M)), .sel(hiSel), .selCount(hiCount)
  );

  assign loLimit = CNT_W'(M) - hiCount;

  rrm_mpe #(.N(N), .CNT_W(CNT_W)) loPass_i (
    .vec(loReq), .limit(loLimit), .sel(loSel), .selCount(loCount)
  );

  assign rawGrant = hiSel | loSel;
  assign anyGrant = (hiCount != '0) || (loCount != '0);
  assign grantVec = strobe.grantEn ? rawGrant : '0;

  // Highest set index of each pass.
  always_comb begin
    hiTop = '0;
    loTop = '0;
    for (int i = 0; i < N; i++) begin
      if (hiSel[i]) hiTop = PTR_W'(i);
      if (loSel[i]) loTop = PTR_W'(i);
    end
  end

  // The wrapped pass is later in scan order than the upper pass.
  assign lastIdx = (loCount != '0) ? loTop : hiTop;
  assign nextPtr = (lastIdx == PTR_W'(N - 1)) ? '0 : lastIdx + PTR_W'(1);
endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acceptIn,
  input  logic             anyGrant,
  input  logic [PTR_W-1:0] nextPtr,
  output logic [PTR_W-1:0] curPtr,
  output rrm_strobe_t      strobe
);
  logic ptrLoad;

  assign strobe.grantEn = acceptIn;
  assign ptrLoad        = acceptIn && anyGrant;

  always_ff @(posedge clk) begin
    if (rst)          curPtr <= '0;
    else if (ptrLoad) curPtr <= nextPtr;
  end
endmodule

// File: rtl/rrm_arbiter.sv
module rrm_arbiter #(
  parameter int N = 8,
  parameter int M = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] reqVec,
  input  logic         acceptIn,
  output logic [N-1:0] grantVec
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam int CNT_W = $clog2(M + 1);

  rrm_pkg::rrm_strobe_t strobe;
  logic [PTR_W-1:0]     curPtr, nextPtr;
  logic                 anyGrant;

  rrm_ctrl #(.PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst(rst), .acceptIn(acceptIn), .anyGrant(anyGrant),
    .nextPtr(nextPtr), .curPtr(curPtr), .strobe(strobe)
  );

  rrm_datapath #(.N(N), .M(M), .PTR_W(PTR_W), .CNT_W(CNT_W)) dp_i (
    .reqVec(reqVec), .curPtr(curPtr), .strobe(strobe),
    .grantVec(grantVec), .anyGrant(anyGrant), .nextPtr(nextPtr)
  );
endmodule

// File: rtl/rrm_arbiter_chk.sv
module rrm_arbiter_chk #(
  parameter int N     = 8,
  parameter int M     = 3,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     reqVec,
  input logic             acceptIn,
  input logic [N-1:0]     grantVec,
  input logic [PTR_W-1:0] curPtr
);
  int reqOnes;
  int expOnes;
  assign reqOnes = $countones(reqVec);
  assign expOnes = (reqOnes < M) ? reqOnes : M;

  a_r1_grant_subset: assert property (@(posedge clk) disable iff (rst)
    (grantVec & ~reqVec) == '0);

  a_r2_grant_count: assert property (@(posedge clk) disable iff (rst)
    acceptIn |-> ($countones(grantVec) == expOnes));

  a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !acceptIn |-> (grantVec == '0));

  a_r6_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    (grantVec == '0) |=> $stable(curPtr));

  a_r7_reset_ptr: assert property (@(posedge clk)
    $past(rst) |-> (curPtr == '0));
endmodule

bind rrm_arbiter rrm_arbiter_chk #(.N(N), .M(M), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .reqVec(reqVec), .acceptIn(acceptIn),
  .grantVec(grantVec), .curPtr(curPtr)
);

// File: tb/rrm_arbiter_tb.sv
module rrm_arbiter_tb_top;
  localparam int N = 8;
  localparam int M = 3;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = (N + M - 1) / M;
  localparam int HIST = 4 * WIN;

  logic         clk = 0;
  logic         rst = 1;
  logic [N-1:0] reqVec = '0;
  logic         acceptIn = 0;
  logic [N-1:0] grantVec;

  int total = 0;
  int bad = 0;
  int mdlPtr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrm_arbiter #(.N(N), .M(M)) dut_i (
    .clk(clk), .rst(rst), .reqVec(reqVec), .acceptIn(acceptIn), .grantVec(grantVec)
  );

  function automatic logic [N-1:0] refGrant(logic [N-1:0] r, bit a, int p);
    logic [N-1:0] g = '0;
    int taken = 0;
    if (!a) return '0;
    for (int k = 0; k < N; k++) begin
      int idx = (p + k) % N;
      if (r[idx] && taken < M) begin g[idx] = 1'b1; taken++; end
    end
    return g;
  endfunction

  function automatic int refNext(logic [N-1:0] g, int p);
    int nxt = p;
    for (int k = 0; k < N; k++) begin
      int idx = (p + k) % N;
      if (g[idx]) nxt = (idx + 1) % N;
    end
    return nxt;
  endfunction

  task automatic chk(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // One cycle: drive, check grants in the same cycle, advance the model.
  task automatic step(logic [N-1:0] r, bit a, string tag, output logic [N-1:0] got);
    logic [N-1:0] exp;
    int ones, expOnes;
    @(negedge clk);
    reqVec = r;
    acceptIn = a;
    #1;
    exp = refGrant(r, a, mdlPtr);
    got = grantVec;
    chk(grantVec === exp, tag, grantVec, exp);
    chk((grantVec & ~r) == '0, "R1 subset", grantVec, r);
    ones = $countones(r);
    expOnes = a ? ((ones < M) ? ones : M) : 0;
    chk($countones(grantVec) == expOnes, "R2 count", grantVec, exp);
    @(posedge clk);
    if (a && exp != '0) mdlPtr = refNext(exp, mdlPtr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] g;
    logic [N-1:0] hist [HIST];
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mdlPtr = 0;

    // R7: after reset, full load grants ports 0..M-1.
    step('1, 1'b1, "R7 reset grant", g);
    chk(g == N'((1 << M) - 1), "R7 low ports", g, N'((1 << M) - 1));

    // R3: accept low blocks grants and holds pointer.
    step('1, 1'b0, "R3 idle", g);
    step(8'b1111_1111, 1'b1, "R3 pointer held", g);

    // R6: no requests leave the pointer where it is.
    step('0, 1'b1, "R6 empty", g);
    step(8'b1010_0101, 1'b1, "R6 pointer held", g);

    // R4/R5: wrap-around corner cases.
    step(8'b1000_0001, 1'b1, "R4 wrap pair", g);
    step(8'b1000_0000, 1'b1, "R5 top port", g);
    step(8'b0000_0011, 1'b1, "R5 after top", g);
    step(8'b0100_0010, 1'b1, "R9 same cycle", g);

    // R8: continuous full load, every window covers all ports.
    for (int c = 0; c < HIST; c++) begin
      step('1, 1'b1, "R8 full load", g);
      hist[c] = g;
    end
    for (int c = 0; c + WIN <= HIST; c++) begin
      logic [N-1:0] u = '0;
      for (int w = 0; w < WIN; w++) u |= hist[c + w];
      chk(u == '1, "R8 starvation window", u, '1);
    end

    // R4/R5/R1/R2: constrained random traffic.
    for (int c = 0; c < 400; c++) begin
      logic [N-1:0] r = N'($urandom);
      bit a = ($urandom % 8) != 0;
      if ($urandom % 4 == 0) r &= N'($urandom);
      step(r, a, "R4 random", g);
    end

    // R7: reset mid-run returns priority to port 0.
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    mdlPtr = 0;
    step('1, 1'b1, "R7 mid reset", g);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule